// File: doc/BRIEF.md
# Debug Address Match and Status Unit

This block watches a core's retired instruction pointer and its data accesses against a set of programmable debug address slots. Each slot carries an address, a kind (instruction execute, data write, I/O, data read-or-write), a length and an enable. When an instruction retires or a data access is presented, every slot is compared at once. The result is recorded in the low bits of a status register, and a debug request is raised toward the exception logic whenever a slot that is enabled has matched.

The block records a match for a slot even when that slot is disabled. It only commits the new status value when an enabled slot hit or when the caller forces the update. The I/O kind is decoded so that it can be programmed, but it never produces a match. Software-visible state is loaded through a single register write port that selects one slot address, the control word or the status word.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset the status output is zero and `dbgReq` is low; all slots hold address zero, kind execute, length one byte, disabled.
- R2: A register write with `regWrSel` equal to n below NUM_SLOTS loads slot n's address. Select NUM_SLOTS loads the control word, and select NUM_SLOTS+1 loads the whole status word. Any other select value changes nothing.
- R3: In the control word, slot n is enabled when bit 2n or bit 2n+1 is set, its kind sits in bits 16+4n..17+4n and its length code in bits 18+4n..19+4n.
- R4: Kind 00 (execute) matches when `instRetire` is high and `instPtr` equals the slot address exactly; length and data inputs do not affect it.
- R5: Kind 01 (data write) matches only when `dataValid` and `dataWrite` are both high and the access overlaps the slot's byte range.
- R6: Kind 11 (data access) matches when `dataValid` is high and the access overlaps the slot's byte range, whether it is a read or a write.
- R7: Kind 10 (I/O) never matches.
- R8: Length code 00 means 1 byte, 01 means 2, 11 means 4 and 10 means 8. The slot range starts at the slot address aligned down to that size. An access covers 2^`dataSize` bytes starting at `dataAddr`. Ranges are compared without wraparound at the top of the address space.
- R9: When an evaluation commits, status bit n becomes 1 exactly for each slot n that matched, enabled or not. The status bits at and above NUM_SLOTS keep their value.
- R10: An evaluation happens in a cycle with `instRetire` or `dataValid` high. It commits only if an enabled slot matched or `forceUpdate` is high. Otherwise the status is unchanged, and `forceUpdate` outside an evaluation has no effect.
- R11: `dbgReq` is high for exactly the cycle after an evaluation in which an enabled slot matched, and low otherwise.
- R12: An evaluation uses the register values from before any write in the same cycle. A committing evaluation takes priority over a status write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Register select: slot address, control or status |
| regWrData | input | 32 | Register write data |
| instRetire | input | 1 | An instruction retires this cycle |
| instPtr | input | 32 | Address of the retiring instruction |
| dataValid | input | 1 | A data access is presented this cycle |
| dataAddr | input | 32 | First byte address of the data access |
| dataSize | input | 2 | Access size as log2 of byte count |
| dataWrite | input | 1 | Data access is a write |
| forceUpdate | input | 1 | Commit status on this evaluation regardless of enables |
| dbgReq | output | 1 | Debug exception request |
| statusOut | output | 32 | Status register |

## Verification
The bench builds the unit with an 8-bit address space, four slots and a 32-bit register width. This makes every data address, every access size and both directions reachable in a full sweep against two slot configurations, with the instruction pointer tied to the data address. Between them the two configurations cover all four kinds and all four length codes, a mix of enabled and disabled slots, and ranges that touch the top of the address space. Directed cycles then cover the commit rules, the write-port decode and same-cycle write collisions.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC   = 2'b00,
    KIND_WRITE  = 2'b01,
    KIND_IO     = 2'b10,
    KIND_ACCESS = 2'b11
  } bpKind_e;

  typedef struct packed {
    logic addrWe;
    logic ctrlWe;
    logic statusWe;
    logic commit;
  } bpStrobes_t;

  // byte span minus one for a slot length code
  function automatic logic [2:0] lenSpan(input logic [1:0] code);
    case (code)
      2'b00:   lenSpan = 3'd0;
      2'b01:   lenSpan = 3'd1;
      2'b11:   lenSpan = 3'd3;
      default: lenSpan = 3'd7;
    endcase
  endfunction

  // byte span minus one for an access size (log2 bytes)
  function automatic logic [2:0] sizeSpan(input logic [1:0] sz);
    case (sz)
      2'b00:   sizeSpan = 3'd0;
      2'b01:   sizeSpan = 3'd1;
      2'b10:   sizeSpan = 3'd3;
      default: sizeSpan = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/bp_slot_match.sv
module bp_slot_match
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        kind,
  input  logic [1:0]        lenCode,
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic              instRetire,
  input  logic [ADDR_W-1:0] instPtr,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  input  logic              dataWrite,
  output logic              hit
);

  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] alignMask;
  logic [EXT_W-1:0]  slotLo;
  logic [EXT_W-1:0]  slotHi;
  logic [EXT_W-1:0]  accLo;
  logic [EXT_W-1:0]  accHi;
  logic              overlap;

  always_comb begin
    alignMask = ~ADDR_W'(lenSpan(lenCode));
    slotLo    = {1'b0, slotAddr & alignMask};
    slotHi    = slotLo + EXT_W'(lenSpan(lenCode));
    accLo     = {1'b0, dataAddr};
    accHi     = accLo + EXT_W'(sizeSpan(dataSize));
    overlap   = (accLo <= slotHi) && (slotLo <= accHi);
  end

  always_comb begin
    case (kind)
      KIND_EXEC:   hit = instRetire && (instPtr == slotAddr);
      KIND_WRITE:  hit = dataValid && dataWrite && overlap;
      KIND_ACCESS: hit = dataValid && overlap;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regWrSel,
  input  logic             instRetire,
  input  logic             dataValid,
  input  logic             forceUpdate,
  input  logic             enabledHit,
  output bpStrobes_t       strobes,
  output logic             dbgReq
);

  localparam logic [SEL_W-1:0] CTRL_SEL   = SEL_W'(NUM_SLOTS);
  localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_SLOTS + 1);

  logic evalEn;

  always_comb begin
    evalEn           = instRetire || dataValid;
    strobes.commit   = evalEn && (enabledHit || forceUpdate);
    strobes.addrWe   = regWrEn && (regWrSel < CTRL_SEL);
    strobes.ctrlWe   = regWrEn && (regWrSel == CTRL_SEL);
    strobes.statusWe = regWrEn && (regWrSel == STATUS_SEL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dbgReq <= 1'b0;
    else       dbgReq <= evalEn && enabledHit;
  end

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 32,
  parameter int SEL_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobes_t        strobes,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              instRetire,
  input  logic [ADDR_W-1:0] instPtr,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  input  logic              dataWrite,
  output logic              enabledHit,
  output logic [REG_W-1:0]  statusOut
);

  localparam int FIELD_BASE = 16;

  logic [ADDR_W-1:0]    slotAddr [NUM_SLOTS];
  logic [1:0]           slotKind [NUM_SLOTS];
  logic [1:0]           slotLen  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotEn;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [REG_W-1:0]     statusReg;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[n] <= '0;
        slotKind[n] <= KIND_EXEC;
        slotLen[n]  <= 2'b00;
        slotEn[n]   <= 1'b0;
      end else begin
        if (strobes.addrWe && (regWrSel == SEL_W'(n)))
          slotAddr[n] <= regWrData[ADDR_W-1:0];
        if (strobes.ctrlWe) begin
          slotEn[n]   <= regWrData[2*n] | regWrData[2*n+1];
          slotKind[n] <= regWrData[FIELD_BASE+4*n +: 2];
          slotLen[n]  <= regWrData[FIELD_BASE+4*n+2 +: 2];
        end
      end
    end

    bp_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .kind       (slotKind[n]),
      .lenCode    (slotLen[n]),
      .slotAddr   (slotAddr[n]),
      .instRetire (instRetire),
      .instPtr    (instPtr),
      .dataValid  (dataValid),
      .dataAddr   (dataAddr),
      .dataSize   (dataSize),
      .dataWrite  (dataWrite),
      .hit        (slotHit[n])
    );
  end

  assign enabledHit = |(slotHit & slotEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 statusReg <= '0;
    else if (strobes.commit)   statusReg <= {statusReg[REG_W-1:NUM_SLOTS], slotHit};
    else if (strobes.statusWe) statusReg <= regWrData;
  end

  assign statusOut = statusReg;

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 32,
  localparam int SEL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              instRetire,
  input  logic [ADDR_W-1:0] instPtr,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [1:0]        dataSize,
  input  logic              dataWrite,
  input  logic              forceUpdate,
  output logic              dbgReq,
  output logic [REG_W-1:0]  statusOut
);

  bpStrobes_t strobes;
  logic       enabledHit;

  bp_control #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrSel    (regWrSel),
    .instRetire  (instRetire),
    .dataValid   (dataValid),
    .forceUpdate (forceUpdate),
    .enabledHit  (enabledHit),
    .strobes     (strobes),
    .dbgReq      (dbgReq)
  );

  bp_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .SEL_W     (SEL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrSel   (regWrSel),
    .regWrData  (regWrData),
    .instRetire (instRetire),
    .instPtr    (instPtr),
    .dataValid  (dataValid),
    .dataAddr   (dataAddr),
    .dataSize   (dataSize),
    .dataWrite  (dataWrite),
    .enabledHit (enabledHit),
    .statusOut  (statusOut)
  );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int REG_W     = 32,
  parameter int SEL_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [SEL_W-1:0] regWrSel,
  input logic             instRetire,
  input logic             dataValid,
  input logic             dbgReq,
  input logic [REG_W-1:0] statusOut
);

  localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_SLOTS + 1);

  // R11
  req_follows_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgReq |-> $past(instRetire || dataValid));

  // R11
  req_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instRetire || dataValid) |=> !dbgReq);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(instRetire || dataValid) && !(regWrEn && regWrSel == STATUS_SEL))
      |=> $stable(statusOut));

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regWrSel == STATUS_SEL) |=> $stable(statusOut[REG_W-1:NUM_SLOTS]));

  // R9
  req_has_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgReq |-> (statusOut[NUM_SLOTS-1:0] != '0));

endmodule

bind dbg_bkpt_unit bp_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .REG_W     (REG_W),
  .SEL_W     (SEL_W)
) u_bp_checker (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regWrSel   (regWrSel),
  .instRetire (instRetire),
  .dataValid  (dataValid),
  .dbgReq     (dbgReq),
  .statusOut  (statusOut)
);

// File: tb/test_dbg_bkpt_unit.sv
`timescale 1ns/1ps
module test_dbg_bkpt_unit;

  localparam int AW = 8;
  localparam int NS = 4;
  localparam int RW = 32;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [SW-1:0] regWrSel = '0;
  logic [RW-1:0] regWrData = '0;
  logic          instRetire = 1'b0;
  logic [AW-1:0] instPtr = '0;
  logic          dataValid = 1'b0;
  logic [AW-1:0] dataAddr = '0;
  logic [1:0]    dataSize = '0;
  logic          dataWrite = 1'b0;
  logic          forceUpdate = 1'b0;
  logic          dbgReq;
  logic [RW-1:0] statusOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0] mAddr [NS];
  logic [31:0]   mCtrl;

  always #2.5 clk = ~clk;

  dbg_bkpt_unit #(.NUM_SLOTS(NS), .ADDR_W(AW), .REG_W(RW)) i_dbg_bkpt_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .instRetire(instRetire), .instPtr(instPtr),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataSize(dataSize),
    .dataWrite(dataWrite), .forceUpdate(forceUpdate), .dbgReq(dbgReq),
    .statusOut(statusOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns at the falling edge after the capturing edge
  task automatic drive(input logic we, input logic [SW-1:0] sel, input logic [31:0] wd,
                       input logic iv, input logic [AW-1:0] ip,
                       input logic dv, input logic [AW-1:0] da, input logic [1:0] ds,
                       input logic dw, input logic fu);
    @(negedge clk);
    regWrEn = we; regWrSel = sel; regWrData = wd;
    instRetire = iv; instPtr = ip;
    dataValid = dv; dataAddr = da; dataSize = ds; dataWrite = dw;
    forceUpdate = fu;
    @(negedge clk);
    regWrEn = 0; regWrSel = '0; regWrData = '0; instRetire = 0; instPtr = '0;
    dataValid = 0; dataAddr = '0; dataSize = '0; dataWrite = 0; forceUpdate = 0;
  endtask

  task automatic writeReg(input logic [SW-1:0] sel, input logic [31:0] wd);
    drive(1'b1, sel, wd, 0, '0, 0, '0, 2'b00, 0, 0);
  endtask

  // R2 R3: program all slots and the control word, mirror them in the model
  task automatic setConfig(input logic [AW-1:0] a0, a1, a2, a3, input logic [31:0] ctrl);
    mAddr[0] = a0; mAddr[1] = a1; mAddr[2] = a2; mAddr[3] = a3; mCtrl = ctrl;
    for (int n = 0; n < NS; n++) writeReg(SW'(n), 32'(mAddr[n]));
    writeReg(SW'(NS), ctrl);
  endtask

  function automatic logic [3:0] enMask();
    for (int n = 0; n < NS; n++) enMask[n] = mCtrl[2*n] | mCtrl[2*n+1];
  endfunction

  // R4 R5 R6 R7 R8: expected match vector from byte counting
  function automatic logic [3:0] model(input int ip, input bit iv, input int da,
                                       input int ds, input bit dw, input bit dv);
    logic [3:0] m = '0;
    for (int n = 0; n < NS; n++) begin
      int kind = int'(mCtrl[16+4*n +: 2]);
      int lc   = int'(mCtrl[18+4*n +: 2]);
      int lenB = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 3) ? 4 : 8;
      int base = (int'(mAddr[n]) / lenB) * lenB;
      bit ov = 0;
      for (int b = 0; b < (1 << ds); b++)
        if ((da + b) >= base && (da + b) < base + lenB) ov = 1;
      case (kind)
        0: m[n] = iv && (ip == int'(mAddr[n]));
        1: m[n] = dv && dw && ov;
        3: m[n] = dv && ov;
        default: m[n] = 0;
      endcase
    end
    return m;
  endfunction

  task automatic sweep(input string tag);
    for (int da = 0; da < 256; da++)
      for (int ds = 0; ds < 4; ds++)
        for (int dw = 0; dw < 2; dw++) begin
          logic [3:0] e;
          bit iv = (ds != 3);
          e = model(da, iv, da, ds, dw[0], 1'b1);
          drive(0, '0, '0, iv, AW'(da), 1'b1, AW'(da), 2'(ds), dw[0], 1'b1);
          chk({"R8 R9 status ", tag}, 32'(statusOut[3:0]), 32'(e));
          chk({"R11 request ", tag}, 32'(dbgReq), 32'(|(e & enMask())));
        end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", statusOut, 32'h0);
    chk("R1 request", 32'(dbgReq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 disabled execute slots at address 0 do not raise a request
    drive(0, '0, '0, 1, 8'h00, 0, '0, 2'b00, 0, 0);
    chk("R1 idle slots", 32'(dbgReq), 32'h0);

    // R2 status write, then ignored selects 6 and 7
    writeReg(3'd5, 32'hA5A5_0000);
    chk("R2 status load", statusOut, 32'hA5A5_0000);
    writeReg(3'd6, 32'h1234_5678);
    writeReg(3'd7, 32'hFFFF_FFFF);
    chk("R2 unused select", statusOut, 32'hA5A5_0000);

    // Config 1: exec, write 2B, io, access 8B; all enabled by mixed bits (R3)
    setConfig(8'h40, 8'h53, 8'h60, 8'h7D, 32'hB250_0099);
    chk("R2 config leaves status", statusOut, 32'hA5A5_0000);
    // R9 enabled hit keeps upper bits
    drive(0, '0, '0, 0, '0, 1, 8'h78, 2'b00, 0, 0);
    chk("R9 upper kept", statusOut, 32'hA5A5_0008);
    chk("R11 request high", 32'(dbgReq), 32'h1);
    drive(0, '0, '0, 0, '0, 0, '0, 2'b00, 0, 0);
    chk("R11 one cycle", 32'(dbgReq), 32'h0);
    // R7 io slot at 0x60 ignored
    drive(0, '0, '0, 0, '0, 1, 8'h60, 2'b11, 1, 0);
    chk("R7 io no match", statusOut, 32'hA5A5_0008);
    // R5 read on write-only slot does not match
    drive(0, '0, '0, 0, '0, 1, 8'h52, 2'b00, 0, 0);
    chk("R5 read ignored", statusOut, 32'hA5A5_0008);
    // R4 execute exact address
    drive(0, '0, '0, 1, 8'h40, 0, '0, 2'b00, 0, 0);
    chk("R4 exec hit", statusOut, 32'hA5A5_0001);
    sweep("cfg1");

    // Config 2: access 4B off, exec 0xFF on, write 8B top on, access 1B off
    setConfig(8'h13, 8'hFF, 8'hFA, 8'h00, 32'h390F_0024);
    writeReg(3'd5, 32'h0000_0F00);
    // R10 disabled-only hit without force leaves status
    drive(0, '0, '0, 0, '0, 1, 8'h10, 2'b00, 0, 0);
    chk("R10 no commit", statusOut, 32'h0000_0F00);
    chk("R10 no request", 32'(dbgReq), 32'h0);
    // R9 R10 forced: disabled match recorded
    drive(0, '0, '0, 0, '0, 1, 8'h10, 2'b00, 0, 1);
    chk("R9 disabled recorded", statusOut, 32'h0000_0F01);
    chk("R11 disabled no request", 32'(dbgReq), 32'h0);
    // R10 force without evaluation
    writeReg(3'd5, 32'h0000_0003);
    drive(0, '0, '0, 0, '0, 0, '0, 2'b00, 0, 1);
    chk("R10 force alone", statusOut, 32'h0000_0003);
    // R6 read and write both hit access slot (forced)
    drive(0, '0, '0, 0, '0, 1, 8'h11, 2'b01, 1, 1);
    chk("R6 write access", statusOut, 32'h0000_0001);
    sweep("cfg2");

    // R12 commit beats status write in same cycle
    writeReg(3'd5, 32'h0000_0000);
    drive(1, 3'd5, 32'hFFFF_0000, 1, 8'hFF, 0, '0, 2'b00, 0, 0);
    chk("R12 commit priority", statusOut, 32'h0000_0002);
    // R12 evaluation sees old slot address during its rewrite
    drive(1, 3'd1, 32'h0000_0010, 1, 8'hFF, 0, '0, 2'b00, 0, 0);
    chk("R12 old address", 32'(dbgReq), 32'h1);
    mAddr[1] = 8'h10;
    drive(0, '0, '0, 1, 8'hFF, 0, '0, 2'b00, 0, 0);
    chk("R12 new address miss", 32'(dbgReq), 32'h0);
    drive(0, '0, '0, 1, 8'h10, 0, '0, 2'b00, 0, 0);
    chk("R12 new address hit", 32'(dbgReq), 32'h1);
    // R3 global-only enable bit on slot 1 via control rewrite
    writeReg(3'd4, 32'h390F_0008);
    drive(0, '0, '0, 1, 8'h10, 0, '0, 2'b00, 0, 0);
    chk("R3 global enable", 32'(dbgReq), 32'h1);
    writeReg(3'd4, 32'h390F_0000);
    drive(0, '0, '0, 1, 8'h10, 0, '0, 2'b00, 0, 0);
    chk("R3 disabled", 32'(dbgReq), 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule